// File: doc/BRIEF.md
# Scanline-Compare Interrupt Generator

This block counts the rendered lines of a video frame and raises a held interrupt when the count reaches a line number that software has programmed. An external timing unit supplies two pulses. The first marks the start of every frame. The second marks one rendered line and arrives only while rendering is on. A small CPU register port writes the target line and the interrupt enable, and reads back a status byte.

The interrupt is a level, not a pulse. Once raised it stays high until software reads the status register. Because the count is forced to zero at every frame boundary, a frame rendered with display output off cannot leave a stale count that would shift the next split point. A target of zero is treated as "off".

The interrupt state is a two-state machine. In `IRQ_IDLE` the output is low, and a compare hit moves the machine to `IRQ_RAISED`. In `IRQ_RAISED` the output is high. A status read with no hit in the same cycle returns the machine to `IRQ_IDLE`, while a hit in that cycle keeps it in `IRQ_RAISED`. Reset enters `IRQ_IDLE`.

Top module: `scanline_irq_gen`

## Requirements
- R1: Reset clears the line counter, the target, the enable and the pending flag. After reset `irq` and `in_frame` are 0, and a target write alone cannot raise `irq` until the enable is written.
- R2: `frame_start` clears the line counter whether or not any line pulses occur. If `frame_start` and `line_tick` fall in the same cycle, the frame start wins and the counter ends at 0. `in_frame` is 1 exactly when the counter is non-zero.
- R3: On each `line_tick`, the target is compared with the counter value before the increment. When enable is 1, the target is non-zero and the two are equal, the pending flag is set and `irq` is 1 from the following cycle.
- R4: Each `line_tick` increments the counter by one, saturating at 2^CNT_W-1 (255 by default). With the target at that maximum, every further tick matches again.
- R5: A target of 0 never raises `irq`, including on the first tick of a frame, when the counter is 0.
- R6: While `cpu_rd` is high with `cpu_addr` equal to STATUS_ADDR (default 0x5204), `cpu_rdata` shows the pending flag in bit 7 and `in_frame` in bit 6, with bits 5..0 at 0, in that same cycle. In all other cycles `cpu_rdata` is 0.
- R7: `irq` equals the pending flag and stays high until a status read. A status read clears it in the next cycle.
- R8: A write to STATUS_ADDR sets the enable from bit 7 of `cpu_wdata`. With the enable at 0 no new interrupt is raised, and clearing the enable leaves an already pending `irq` high.
- R9: If a status read and a compare hit fall in the same cycle, the read returns the old flag and `irq` is 1 afterwards.
- R10: A write to TARGET_ADDR (default 0x5203) loads the low CNT_W bits of `cpu_wdata` as the target line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at each frame boundary |
| line_tick | input | 1 | One-cycle pulse per rendered line |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | ADDR_W | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data (status byte) |
| irq | output | 1 | Held interrupt level |
| in_frame | output | 1 | Counter is non-zero |

## Verification
The bench builds the block with CNT_W set to 4, so the counter saturates at 15 instead of 255. This lets the bench reach the saturation ceiling, and show that the maximum target keeps matching after saturation, within a few dozen line pulses. The same narrow width makes a target write of 0x13 truncate to 3, which shows that only the low CNT_W bits of a target write are kept. The addresses keep their default values, so the status and target decodes are checked at 0x5204 and 0x5203.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;
    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    localparam int STATUS_PEND_BIT  = 7;
    localparam int STATUS_FRAME_BIT = 6;
    localparam int ENABLE_BIT       = 7;
endpackage

// File: rtl/scanline_irq_regs.sv
module scanline_irq_regs #(
    parameter int                ADDR_W      = 16,
    parameter int                CNT_W       = 8,
    parameter logic [ADDR_W-1:0] TARGET_ADDR = 16'h5203,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'h5204
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [CNT_W-1:0]  target_q,
    output logic              enable_q,
    output logic              rd_status
);
    import scanline_irq_pkg::*;

    logic wr_target;
    logic wr_status;

    assign wr_target = cpu_wr && (cpu_addr == TARGET_ADDR);
    assign wr_status = cpu_wr && (cpu_addr == STATUS_ADDR);
    assign rd_status = cpu_rd && (cpu_addr == STATUS_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target_q <= '0;
            enable_q <= 1'b0;
        end else begin
            if (wr_target) target_q <= cpu_wdata[CNT_W-1:0];
            if (wr_status) enable_q <= cpu_wdata[ENABLE_BIT];
        end
    end
endmodule

// File: rtl/scanline_irq_linecnt.sv
module scanline_irq_linecnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             line_tick,
    input  logic             enable_q,
    input  logic [CNT_W-1:0] target_q,
    output logic [CNT_W-1:0] count_q,
    output logic             in_frame,
    output logic             hit
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic tick_eff;

    assign tick_eff = line_tick && !frame_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (frame_start) begin
            count_q <= '0;
        end else if (line_tick && (count_q != CNT_MAX)) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign in_frame = (count_q != '0);
    assign hit      = tick_eff && enable_q && (target_q != '0) && (count_q == target_q);
endmodule

// File: rtl/scanline_irq_fsm.sv
module scanline_irq_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic rd_status,
    output logic irq
);
    import scanline_irq_pkg::*;

    irq_state_e state_q;
    irq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (hit)                state_d = IRQ_RAISED;
            IRQ_RAISED: if (rd_status && !hit)  state_d = IRQ_IDLE;
            default:                            state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end
endmodule

// File: rtl/scanline_irq_gen.sv
module scanline_irq_gen #(
    parameter int                ADDR_W      = 16,
    parameter int                CNT_W       = 8,
    parameter logic [ADDR_W-1:0] TARGET_ADDR = 16'h5203,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'h5204
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_tick,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic              irq,
    output logic              in_frame
);
    import scanline_irq_pkg::*;

    logic [CNT_W-1:0] target_q;
    logic [CNT_W-1:0] count_q;
    logic             enable_q;
    logic             rd_status;
    logic             hit;

    scanline_irq_regs #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .TARGET_ADDR(TARGET_ADDR), .STATUS_ADDR(STATUS_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .target_q(target_q), .enable_q(enable_q), .rd_status(rd_status)
    );

    scanline_irq_linecnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .line_tick(line_tick), .enable_q(enable_q), .target_q(target_q),
        .count_q(count_q), .in_frame(in_frame), .hit(hit)
    );

    scanline_irq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hit(hit), .rd_status(rd_status), .irq(irq)
    );

    always_comb begin
        cpu_rdata = '0;
        if (rd_status) begin
            cpu_rdata[STATUS_PEND_BIT]  = irq;
            cpu_rdata[STATUS_FRAME_BIT] = in_frame;
        end
    end
endmodule

// File: rtl/scanline_irq_chk.sv
module scanline_irq_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             line_tick,
    input logic             rd_status,
    input logic             hit,
    input logic             enable_q,
    input logic [CNT_W-1:0] target_q,
    input logic [CNT_W-1:0] count_q,
    input logic [7:0]       cpu_rdata,
    input logic             irq,
    input logic             in_frame
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assert_frame_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !in_frame);

    assert_hit_raise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> irq);

    assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && !frame_start && count_q == CNT_MAX) |=> (count_q == CNT_MAX));

    assert_zero_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (target_q == '0 && !irq) |=> !irq);

    assert_status_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status |-> (cpu_rdata[7] == irq && cpu_rdata[6] == in_frame && cpu_rdata[5:0] == 6'd0));

    assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rd_status) |=> irq);

    assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !line_tick) |=> !irq);

    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_q && !irq) |=> !irq);

    assert_read_hit_race_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && hit) |=> irq);
endmodule

bind scanline_irq_gen scanline_irq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_tick(line_tick),
    .rd_status(rd_status), .hit(hit), .enable_q(enable_q), .target_q(target_q),
    .count_q(count_q), .cpu_rdata(cpu_rdata), .irq(irq), .in_frame(in_frame)
);

// File: tb/sim_scanline_irq_gen.sv
`timescale 1ns/1ps
module sim_scanline_irq_gen;
    localparam int CNT_W = 4;
    localparam int MAXV  = (1 << CNT_W) - 1;
    localparam logic [15:0] A_TGT = 16'h5203;
    localparam logic [15:0] A_ST  = 16'h5204;

    // ops
    localparam logic [3:0] OP_FRAME = 4'd0, OP_TICK = 4'd1, OP_WTGT = 4'd2,
                           OP_WEN = 4'd3, OP_RDST = 4'd4, OP_TICKRD = 4'd5, OP_FT = 4'd6;

    // {op, data, exp_rdata, exp_irq, exp_in_frame, req}
    localparam int NV = 28;
    localparam logic [25:0] VEC [NV] = '{
        {OP_WEN,   8'h80, 8'h00, 1'b0, 1'b0, 4'd8},  // R8
        {OP_WTGT,  8'h03, 8'h00, 1'b0, 1'b0, 4'd10}, // R10
        {OP_FRAME, 8'h00, 8'h00, 1'b0, 1'b0, 4'd2},  // R2
        {OP_TICK,  8'h00, 8'h00, 1'b0, 1'b1, 4'd4},  // R4
        {OP_TICK,  8'h00, 8'h00, 1'b0, 1'b1, 4'd3},  // R3
        {OP_TICK,  8'h00, 8'h00, 1'b0, 1'b1, 4'd3},  // R3
        {OP_TICK,  8'h00, 8'h00, 1'b1, 1'b1, 4'd3},  // R3 hit at count 3
        {OP_TICK,  8'h00, 8'h00, 1'b1, 1'b1, 4'd7},  // R7 held
        {OP_RDST,  8'h00, 8'hC0, 1'b0, 1'b1, 4'd6},  // R6 / R7
        {OP_RDST,  8'h00, 8'h40, 1'b0, 1'b1, 4'd7},  // R7
        {OP_FRAME, 8'h00, 8'h00, 1'b0, 1'b0, 4'd2},  // R2 without ticks
        {OP_WTGT,  8'h00, 8'h00, 1'b0, 1'b0, 4'd5},  // R5
        {OP_TICK,  8'h00, 8'h00, 1'b0, 1'b1, 4'd5},  // R5 count 0 vs target 0
        {OP_TICK,  8'h00, 8'h00, 1'b0, 1'b1, 4'd5},  // R5
        {OP_WEN,   8'h00, 8'h00, 1'b0, 1'b1, 4'd8},  // R8
        {OP_WTGT,  8'h02, 8'h00, 1'b0, 1'b1, 4'd8},  // R8
        {OP_FRAME, 8'h00, 8'h00, 1'b0, 1'b0, 4'd2},  // R2
        {OP_TICK,  8'h00, 8'h00, 1'b0, 1'b1, 4'd8},  // R8
        {OP_TICK,  8'h00, 8'h00, 1'b0, 1'b1, 4'd8},  // R8
        {OP_TICK,  8'h00, 8'h00, 1'b0, 1'b1, 4'd8},  // R8 passes target, disabled
        {OP_RDST,  8'h00, 8'h40, 1'b0, 1'b1, 4'd6},  // R6
        {OP_WEN,   8'h80, 8'h00, 1'b0, 1'b1, 4'd8},  // R8
        {OP_FRAME, 8'h00, 8'h00, 1'b0, 1'b0, 4'd2},  // R2
        {OP_TICK,  8'h00, 8'h00, 1'b0, 1'b1, 4'd4},  // R4
        {OP_TICK,  8'h00, 8'h00, 1'b0, 1'b1, 4'd4},  // R4
        {OP_TICKRD,8'h00, 8'h40, 1'b1, 1'b1, 4'd9},  // R9 read+hit
        {OP_WEN,   8'h00, 8'h00, 1'b1, 1'b1, 4'd8},  // R8 disable keeps pending
        {OP_RDST,  8'h00, 8'hC0, 1'b0, 1'b1, 4'd7}   // R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0, line_tick = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        irq, in_frame;
    logic [7:0]  rd_cap;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    scanline_irq_gen #(.ADDR_W(16), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_tick(line_tick),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .irq(irq), .in_frame(in_frame)
    );

    task automatic check(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input logic [3:0] op, input logic [7:0] data);
        @(negedge clk);
        case (op)
            OP_FRAME:  frame_start = 1'b1;
            OP_TICK:   line_tick = 1'b1;
            OP_WTGT:   begin cpu_wr = 1'b1; cpu_addr = A_TGT; cpu_wdata = data; end
            OP_WEN:    begin cpu_wr = 1'b1; cpu_addr = A_ST;  cpu_wdata = data; end
            OP_RDST:   begin cpu_rd = 1'b1; cpu_addr = A_ST; end
            OP_TICKRD: begin cpu_rd = 1'b1; cpu_addr = A_ST; line_tick = 1'b1; end
            OP_FT:     begin frame_start = 1'b1; line_tick = 1'b1; end
            default: ;
        endcase
        #1 rd_cap = cpu_rdata;
        @(negedge clk);
        frame_start = 1'b0; line_tick = 1'b0; cpu_wr = 1'b0; cpu_rd = 1'b0;
        cpu_addr = '0; cpu_wdata = '0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(1, "irq in reset", {7'd0, irq}, 8'd0);
        check(1, "in_frame in reset", {7'd0, in_frame}, 8'd0);
        rst_n = 1'b1;
        do_op(OP_RDST, 8'h00);
        check(6, "status after reset", rd_cap, 8'h00);
        // R6: no status read -> rdata 0
        check(6, "rdata idle", cpu_rdata, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [3:0] op; logic [7:0] dat, erd; logic ei, ef; logic [3:0] rq;
            {op, dat, erd, ei, ef, rq} = VEC[i];
            do_op(op, dat);
            check(int'(rq), $sformatf("vec %0d irq", i), {7'd0, irq}, {7'd0, ei});
            check(int'(rq), $sformatf("vec %0d in_frame", i), {7'd0, in_frame}, {7'd0, ef});
            if (op == OP_RDST || op == OP_TICKRD)
                check(int'(rq), $sformatf("vec %0d rdata", i), rd_cap, erd);
        end

        // R4: saturation with target at maximum
        do_op(OP_WEN, 8'h80);
        do_op(OP_WTGT, 8'(MAXV));
        do_op(OP_FRAME, 8'h00);
        for (int k = 0; k < MAXV; k++) do_op(OP_TICK, 8'h00);
        check(4, "no fire before max compare", {7'd0, irq}, 8'd0);
        do_op(OP_TICK, 8'h00);
        check(4, "fire at max", {7'd0, irq}, 8'd1);
        do_op(OP_RDST, 8'h00);
        check(7, "cleared by read", {7'd0, irq}, 8'd0);
        do_op(OP_TICK, 8'h00);
        check(4, "refire while saturated", {7'd0, irq}, 8'd1);
        do_op(OP_RDST, 8'h00);

        // R2: frame start beats same-cycle tick
        do_op(OP_FT, 8'h00);
        check(2, "frame+tick in_frame", {7'd0, in_frame}, 8'd0);

        // R10: target write keeps low CNT_W bits (0x13 -> 3)
        do_op(OP_WTGT, 8'h13);
        do_op(OP_FRAME, 8'h00);
        for (int k = 0; k < 3; k++) do_op(OP_TICK, 8'h00);
        check(10, "no fire before truncated target", {7'd0, irq}, 8'd0);
        do_op(OP_TICK, 8'h00);
        check(10, "fire at truncated target 3", {7'd0, irq}, 8'd1);

        // R1: reset mid-run clears pending, counter and enable
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(1, "irq after reset", {7'd0, irq}, 8'd0);
        check(1, "in_frame after reset", {7'd0, in_frame}, 8'd0);
        rst_n = 1'b1;
        do_op(OP_WTGT, 8'h01);
        do_op(OP_FRAME, 8'h00);
        do_op(OP_TICK, 8'h00);
        do_op(OP_TICK, 8'h00);
        check(1, "enable cleared by reset", {7'd0, irq}, 8'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule